// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Edge-Latched Interrupt

This block is an eight-pin general-purpose I/O controller attached to a small register bus. Software samples pin levels through a read-only level register. Output values are changed only through two write-one strobe registers, one that sets bits and one that clears them. A direction register switches each pin between driving and listening.

Every pin input passes through a two-flop synchroniser. Transitions are found by comparing the synchronised sample with the sample one cycle older. Each pin has separate enables for rising and for falling edges. A qualifying transition latches a sticky status bit, which software clears by writing a one to it. A mask register selects which latched bits reach the single interrupt line. Masking is applied after latching, so a masked pin still records its events.

The bus has no wait states. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`. The asynchronous reset input is released synchronously inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: While in reset and after reset, all registers are zero, so `pin_oe`, `pin_out` and `irq` are 0 and every register reads 0.
- R2: A read at byte offset 0x00 returns each pin's level as seen through two clock edges of synchronisation. Writes to 0x00 change nothing.
- R3: A write to offset 0x08 sets the output-latch bits that are 1 in the data and leaves the other bits alone. `pin_out` shows the latch. Reads at 0x08 and 0x0C both return the latch.
- R4: A write to offset 0x0C clears the output-latch bits that are 1 in the data and leaves the other bits alone.
- R5: Offset 0x04 holds the direction bits, where bit i set to 1 makes pin i an output. `pin_oe` equals this register.
- R6: When bit i of the rising-enable register (offset 0x10) is 1, a 0-to-1 change of the synchronised pin i sets status bit i.
- R7: When bit i of the falling-enable register (offset 0x14) is 1, a 1-to-0 change of the synchronised pin i sets status bit i.
- R8: Status (offset 0x18) bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: When an edge event and a write-one-clear hit the same status bit on the same clock edge, the bit ends up set.
- R10: `irq` is 1 exactly when some bit is 1 in both the status register and the mask register (offset 0x1C). Masking does not stop status bits from latching.
- R11: An address whose two low bits are not zero reads as 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 8 | Write data, bit i for pin i |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Per-pin output enable (direction) |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` are stable around each rising clock edge. They also assume that the pins are low while reset is released, since the edge history starts from zero. The bench changes every input on the falling edge and keeps `pin_in` at zero through reset. Random writes go to both aligned and unaligned offsets, and random pin toggles are mixed in, including status clears that coincide with fresh edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned GPIO_ADDR_W = 5;

  typedef enum logic [3:0] {
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_RISE,
    SEL_FALL,
    SEL_STAT,
    SEL_MASK,
    SEL_NONE
  } gpio_sel_e;

  // Word slot is addr[4:2]; any byte offset within a word decodes to nothing.
  function automatic gpio_sel_e gpio_decode(input logic [GPIO_ADDR_W-1:0] addr);
    gpio_sel_e sel;
    if (addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else begin
      case (addr[4:2])
        3'd0:    sel = SEL_LEVEL;
        3'd1:    sel = SEL_DIR;
        3'd2:    sel = SEL_SET;
        3'd3:    sel = SEL_CLR;
        3'd4:    sel = SEL_RISE;
        3'd5:    sel = SEL_FALL;
        3'd6:    sel = SEL_STAT;
        default: sel = SEL_MASK;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        hist_q <= sync_q;
      end
    end

    assign level[i] = sync_q;
    assign rise[i]  = sync_q & ~hist_q;
    assign fall[i]  = ~sync_q & hist_q;
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = GPIO_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  level,
  input  logic [NPINS-1:0]  rise,
  input  logic [NPINS-1:0]  fall,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  out_lat,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  mask
);

  gpio_sel_e sel;
  logic dir_we, lat_we, ren_we, fen_we, mask_we, stat_we;
  logic [NPINS-1:0] lat_q, lat_d;
  logic [NPINS-1:0] dir_q, ren_q, fen_q, mask_q;
  logic [NPINS-1:0] stat_q, stat_d, events, clr_bits;

  assign sel = gpio_decode(addr);

  // Clock enables
  always_comb begin
    dir_we  = wr && (sel == SEL_DIR);
    lat_we  = wr && ((sel == SEL_SET) || (sel == SEL_CLR));
    ren_we  = wr && (sel == SEL_RISE);
    fen_we  = wr && (sel == SEL_FALL);
    mask_we = wr && (sel == SEL_MASK);
    stat_we = wr && (sel == SEL_STAT);
  end

  // Next state
  always_comb begin
    if (sel == SEL_SET) lat_d = lat_q | wdata;
    else                lat_d = lat_q & ~wdata;
    events   = (rise & ren_q) | (fall & fen_q);
    clr_bits = stat_we ? wdata : '0;
    stat_d   = (stat_q & ~clr_bits) | events;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (lat_we)  lat_q  <= lat_d;
      if (dir_we)  dir_q  <= wdata;
      if (ren_we)  ren_q  <= wdata;
      if (fen_we)  fen_q  <= wdata;
      if (mask_we) mask_q <= wdata;
      stat_q <= stat_d;
    end
  end

  // Read mux
  always_comb begin
    case (sel)
      SEL_LEVEL: rdata = level;
      SEL_DIR:   rdata = dir_q;
      SEL_SET:   rdata = lat_q;
      SEL_CLR:   rdata = lat_q;
      SEL_RISE:  rdata = ren_q;
      SEL_FALL:  rdata = fen_q;
      SEL_STAT:  rdata = stat_q;
      SEL_MASK:  rdata = mask_q;
      default:   rdata = '0;
    endcase
  end

  assign out_lat = lat_q;
  assign dir     = dir_q;
  assign status  = stat_q;
  assign mask    = mask_q;

  AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_SET) |=> ((lat_q & $past(lat_q)) == $past(lat_q))); // R3
  AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CLR) |=> ((lat_q & ~$past(lat_q)) == '0)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_DIR) |=> $stable(dir_q)); // R5
  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_STAT) |=> ((stat_q & $past(wdata) & ~$past(events)) == '0)); // R8
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && sel == SEL_STAT) && events == '0) |=> $stable(stat_q)); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (events != '0) |=> ((stat_q & $past(events)) == $past(events))); // R9
  AST_ODD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> (rdata == '0)); // R11

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = GPIO_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic             rst_n_int;
  logic [NPINS-1:0] level, rise, fall;
  logic [NPINS-1:0] status, mask;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pin_in (pin_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .level   (level),
    .rise    (rise),
    .fall    (fall),
    .rdata   (bus_rdata),
    .out_lat (pin_out),
    .dir     (pin_oe),
    .status  (status),
    .mask    (mask)
  );

  assign irq = |(status & mask);

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mask == '0) |-> !irq); // R10
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> (status != '0)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_int |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R1

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] m_lat, m_dir, m_ren, m_fen, m_stat, m_mask, m_s1, m_s2, m_prev;

  always #(CLK_P/2) clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always @(posedge clk) begin
    logic [7:0] ev, clr;
    if (!rst_n) begin
      m_lat <= 0; m_dir <= 0; m_ren <= 0; m_fen <= 0; m_stat <= 0;
      m_mask <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
    end else begin
      ev  = ((m_s2 & ~m_prev) & m_ren) | ((~m_s2 & m_prev) & m_fen);
      clr = 8'h00;
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (bus_wr && bus_addr[1:0] == 2'b00) begin
        case (bus_addr[4:2])
          3'd1: m_dir  <= bus_wdata;
          3'd2: m_lat  <= m_lat | bus_wdata;
          3'd3: m_lat  <= m_lat & ~bus_wdata;
          3'd4: m_ren  <= bus_wdata;
          3'd5: m_fen  <= bus_wdata;
          3'd6: clr    = bus_wdata;
          3'd7: m_mask <= bus_wdata;
          default: ;
        endcase
      end
      m_stat <= (m_stat & ~clr) | ev;
    end
  end

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 8'h00;
    case (a[4:2])
      3'd0: return m_s2;
      3'd1: return m_dir;
      3'd2, 3'd3: return m_lat;
      3'd4: return m_ren;
      3'd5: return m_fen;
      3'd6: return m_stat;
      default: return m_mask;
    endcase
  endfunction

  function automatic string read_tag(input logic [4:0] a);
    if (a[1:0] != 2'b00) return "R11";
    case (a[4:2])
      3'd0: return "R2";
      3'd1: return "R5";
      3'd2, 3'd3: return "R3";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic chk_ports();
    chk(pin_out, m_lat, "R3", "pin_out");
    chk(pin_oe, m_dir, "R5", "pin_oe");
    chk({7'd0, irq}, {7'd0, |(m_stat & m_mask)}, "R10", "irq");
  endtask

  // Apply one bus cycle at a falling edge, then check ports at the next falling edge.
  task automatic cyc(input logic w, input logic [4:0] a, input logic [7:0] d,
                     input logic [7:0] p);
    bus_wr = w; bus_addr = a; bus_wdata = d; pin_in = p;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    chk_ports();
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata, exp_read(a), tag, $sformatf("read @%02h", a));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pins;
    void'($urandom(32'h5eed_61f0));
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    chk(pin_oe, 8'h00, "R1", "pin_oe in reset");
    chk(pin_out, 8'h00, "R1", "pin_out in reset");
    chk({7'd0, irq}, 8'h00, "R1", "irq in reset");
    rst_n = 1'b1;
    repeat (3) cyc(0, 5'h00, 8'h00, 8'h00);
    for (int a = 0; a < 32; a += 4) rd(5'(a), "R1");

    // R2: level register ignores writes
    cyc(1, 5'h00, 8'hFF, 8'h00);
    rd(5'h00, "R2");
    rd(5'h04, "R2");
    // R3 / R4
    cyc(1, 5'h08, 8'hA5, 8'h00);
    chk(pin_out, 8'hA5, "R3", "set write");
    cyc(1, 5'h08, 8'h00, 8'h00);
    chk(pin_out, 8'hA5, "R3", "set with zeros");
    cyc(1, 5'h0C, 8'h05, 8'h00);
    chk(pin_out, 8'hA0, "R4", "clear write");
    rd(5'h0C, "R3");
    rd(5'h08, "R3");
    // R5
    cyc(1, 5'h04, 8'hF0, 8'h00);
    chk(pin_oe, 8'hF0, "R5", "direction");
    // R11: unaligned write ignored
    cyc(1, 5'h05, 8'hFF, 8'h00);
    chk(pin_oe, 8'hF0, "R11", "unaligned write");
    rd(5'h05, "R11");
    rd(5'h1B, "R11");
    // R6 / R7 / R10
    cyc(1, 5'h10, 8'h01, 8'h00);
    cyc(1, 5'h14, 8'h02, 8'h00);
    cyc(1, 5'h1C, 8'h03, 8'h00);
    repeat (3) cyc(0, 5'h00, 8'h00, 8'h03);
    bus_addr = 5'h18; #1;
    chk(bus_rdata, 8'h01, "R6", "rising only on pin0");
    chk({7'd0, irq}, 8'h01, "R10", "irq on masked status");
    rd(5'h00, "R2");
    repeat (3) cyc(0, 5'h00, 8'h00, 8'h00);
    bus_addr = 5'h18; #1;
    chk(bus_rdata, 8'h03, "R7", "falling on pin1");
    // R8
    cyc(1, 5'h18, 8'h00, 8'h00);
    bus_addr = 5'h18; #1;
    chk(bus_rdata, 8'h03, "R8", "zero write keeps status");
    cyc(1, 5'h18, 8'h01, 8'h00);
    bus_addr = 5'h18; #1;
    chk(bus_rdata, 8'h02, "R8", "w1c bit0");
    // R10: mask gates irq but not latching
    cyc(1, 5'h1C, 8'h00, 8'h00);
    chk({7'd0, irq}, 8'h00, "R10", "masked irq off");
    cyc(0, 5'h00, 8'h00, 8'h01);
    cyc(0, 5'h00, 8'h00, 8'h01);
    // R9: edge event is live now; clear the same bit this cycle
    cyc(1, 5'h18, 8'h01, 8'h01);
    bus_addr = 5'h18; #1;
    chk(bus_rdata, 8'h03, "R9", "edge beats clear");
    cyc(1, 5'h18, 8'hFF, 8'h01);
    bus_addr = 5'h18; #1;
    chk(bus_rdata, 8'h00, "R8", "clear all");

    // Random phase
    pins = 8'h01;
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] a;
      logic       w;
      a = ($urandom % 8 == 0) ? 5'($urandom) : 5'(($urandom % 8) * 4);
      rd(5'(($urandom % 8) * 4), read_tag(a));
      if ($urandom % 3 == 0) pins = pins ^ (8'h1 << ($urandom % 8));
      w = ($urandom % 2) == 1;
      cyc(w, a, 8'($urandom), pins);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule